// File: doc/BRIEF.md
# Subcarrier load-modulation tag transmitter

This block sends a tag's response back to a reader by switching a subcarrier on and off. A free-running divider splits the carrier-rate clock by 64. Its top bit is the subcarrier square wave, and its wrap marks one protocol tick. A response is either a data frame of up to 12 bits or a single write-acknowledge bit. The response is handed over through a valid/ready request at the moment the reader frame ends, and that cycle is the time reference for the start delay. Data frames begin after 70 ticks. An acknowledge begins after 758 ticks. Each bit then holds one 21-tick slot, least significant bit first.

Data bits are scrambled with a keystream bit supplied from outside. The block pulses `ks_adv` whenever the keystream source must step, so the source stays aligned with the elapsed slots. During the start delay it issues one strobe for each idle slot except the last: 2 strobes for data frames and 35 for an acknowledge. It then issues one strobe for each bit sent. The acknowledge bit is always a plain 1.

Back-pressure: `req_ready` is high only while the block is idle. A request whose `req_valid` is held while the block is busy waits unchanged and is taken in the first idle cycle. The earliest such cycle is the one in which `done` pulses.

Top module: `tagtx_top`

## Requirements
- R1: In reset and in the first idle cycle after it, `mod_out`, `busy`, `done` and `ks_adv` are low and `req_ready` is high.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low while `busy` is high. A held request is accepted in the cycle where `done` pulses.
- R3: For a data frame, the first slot begins between 69·P+2 and 70·P+1 clock cycles after the acceptance cycle, where P = 2^DIV_LOG2 is the number of clocks per tick.
- R4: Slots are exactly 21·P cycles long and follow each other with no gap. Slot k carries bit k of the frame, so bit 0 (the LSB) goes first.
- R5: Slot k's level is `req_data[k]` XOR the `ks_bit` value present in the cycle just before the slot. That cycle carries a `ks_adv` strobe.
- R6: Before the first slot's strobe, exactly 2 strobes occur for a data frame and 35 for an acknowledge. The total number of strobes per response is that count plus the number of slots.
- R7: During a slot carrying a 1, `mod_out` follows the subcarrier (divider bit DIV_LOG2-1), which is high for exactly half of the slot's cycles. During a slot carrying a 0, `mod_out` stays low.
- R8: `mod_out` stays low while the block is idle, during the start delay and after the last slot.
- R9: With `req_ack` high, the block sends one slot of value 1, ignoring `req_data`, `req_len` and `ks_bit`. The slot begins between 757·P+2 and 758·P+1 cycles after acceptance.
- R10: A `req_len` above 12 is clamped to 12 slots. A `req_len` of 0 sends no slot: the block waits out the 70-tick delay, gives its 2 strobes and finishes.
- R11: `done` is a single-cycle pulse in the cycle right after the last slot's final cycle (or after the delay when there is no slot). `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Response request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_ack | input | 1 | 1: send write acknowledge instead of data |
| req_data | input | 12 | Response bits, bit 0 sent first |
| req_len | input | 4 | Number of data bits (clamped to 12) |
| busy | output | 1 | Response in progress |
| done | output | 1 | One-cycle pulse at end of response |
| ks_adv | output | 1 | Keystream step strobe |
| ks_bit | input | 1 | Current keystream bit |
| mod_out | output | 1 | Gated subcarrier to the modulator |

## Verification
Two events can fall in the same cycle: the end-of-response `done` pulse, and the acceptance of a request that was held waiting. The bench keeps `req_valid` high with a second frame throughout the first frame. It then requires the acceptance cycle of the second frame to equal the `done` cycle of the first, with the second frame's timing and content still correct. Each frame is judged against a cycle history of `mod_out`, read back from the `done` cycle. A bench-side keystream model records the value and cycle of every strobe, and the expected slot levels are computed from those records.

// File: rtl/tagtx_pkg.sv
package tagtx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;
endpackage

// File: rtl/tagtx_subcarrier.sv
module tagtx_subcarrier #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic carrier,
  output logic tick
);
  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign carrier = div_q[DIV_LOG2-1];
  assign tick    = &div_q;

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R7
endmodule

// File: rtl/tagtx_slot_timer.sv
module tagtx_slot_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire = tick && (cnt_q == CNT_W'(1));

  AST_NO_RELOAD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0 || expire)); // R4
endmodule

// File: rtl/tagtx_serializer.sv
module tagtx_serializer #(
  parameter int MAX_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] load_data,
  input  logic                launch,
  input  logic                force_one,
  input  logic                ks_bit,
  input  logic                clear,
  output logic                out_bit
);
  logic [MAX_BITS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      out_bit <= 1'b0;
    end else begin
      if (load)
        sh_q <= load_data;
      else if (launch)
        sh_q <= sh_q >> 1;
      if (launch)
        out_bit <= force_one ? 1'b1 : (sh_q[0] ^ ks_bit);
      else if (clear)
        out_bit <= 1'b0;
    end
  end

  AST_LOAD_LAUNCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && launch)); // R2
endmodule

// File: rtl/tagtx_top.sv
module tagtx_top #(
  parameter int DIV_LOG2   = 6,
  parameter int SLOT_TICKS = 21,
  parameter int DATA_WAIT  = 70,
  parameter int ACK_WAIT   = 758,
  parameter int MAX_BITS   = 12,
  parameter int LEN_W      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_ack,
  input  logic [MAX_BITS-1:0] req_data,
  input  logic [LEN_W-1:0]    req_len,
  output logic                busy,
  output logic                done,
  output logic                ks_adv,
  input  logic                ks_bit,
  output logic                mod_out
);
  import tagtx_pkg::*;

  localparam int DATA_PRE = DATA_WAIT / SLOT_TICKS - 1;
  localparam int ACK_PRE  = ACK_WAIT / SLOT_TICKS - 1;
  localparam int CNT_W    = $clog2(ACK_WAIT + 1);
  localparam int PRE_W    = $clog2(ACK_PRE + 1);
  localparam int BITS_W   = $clog2(MAX_BITS + 1);

  tx_state_e         state_q;
  logic [PRE_W-1:0]  pre_left_q;
  logic [BITS_W-1:0] bits_left_q;
  logic              ack_q;

  logic carrier, tick, expire, out_bit;
  logic accept, launch, finish, tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic [BITS_W-1:0] eff_len;

  tagtx_subcarrier #(.DIV_LOG2(DIV_LOG2)) u_sub (
    .clk(clk), .rst_n(rst_n), .carrier(carrier), .tick(tick));

  tagtx_slot_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .tick(tick), .expire(expire));

  tagtx_serializer #(.MAX_BITS(MAX_BITS)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(req_data),
    .launch(launch), .force_one(ack_q), .ks_bit(ks_bit),
    .clear(finish), .out_bit(out_bit));

  assign req_ready = (state_q == TX_IDLE);
  assign busy      = (state_q != TX_IDLE);
  assign accept    = req_valid && req_ready;
  assign launch    = busy && expire && (bits_left_q != '0);
  assign finish    = busy && expire && (bits_left_q == '0);
  assign ks_adv    = ((state_q == TX_WAIT) && (pre_left_q != '0)) || launch;
  assign tmr_load  = accept || launch;
  assign tmr_val   = accept ? (req_ack ? CNT_W'(ACK_WAIT) : CNT_W'(DATA_WAIT))
                          : CNT_W'(SLOT_TICKS);
  assign eff_len   = (32'(req_len) > MAX_BITS) ? BITS_W'(MAX_BITS) : BITS_W'(req_len);
  assign mod_out   = out_bit && carrier && (state_q == TX_SEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= TX_IDLE;
      pre_left_q  <= '0;
      bits_left_q <= '0;
      ack_q       <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        state_q     <= TX_WAIT;
        ack_q       <= req_ack;
        pre_left_q  <= req_ack ? PRE_W'(ACK_PRE) : PRE_W'(DATA_PRE);
        bits_left_q <= req_ack ? BITS_W'(1) : eff_len;
      end else begin
        if ((state_q == TX_WAIT) && (pre_left_q != '0))
          pre_left_q <= pre_left_q - 1'b1;
        if (launch) begin
          state_q     <= TX_SEND;
          bits_left_q <= bits_left_q - 1'b1;
        end else if (finish) begin
          state_q <= TX_IDLE;
        end
      end
    end
  end

  AST_PRE_BEFORE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TX_WAIT) && expire) |-> (pre_left_q == '0)); // R6
  AST_ACK_IS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && ack_q) |=> out_bit); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_SLOT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TX_SEND) && !expire) |=> $stable(out_bit)); // R4
  AST_BITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bits_left_q) <= MAX_BITS); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != TX_SEND) |-> !mod_out); // R8
endmodule

// File: tb/tagtx_top_tb.sv
module tagtx_top_tb;
  localparam int DL   = 3;
  localparam int P    = 1 << DL;
  localparam int S    = 21 * P;
  localparam int NVEC = 8;

  // {ack, len[3:0], data[11:0]}
  localparam logic [16:0] VEC [0:NVEC-1] = '{
    {1'b0, 4'd12, 12'hA5C},
    {1'b0, 4'd12, 12'hFFF},
    {1'b0, 4'd1,  12'h001},
    {1'b0, 4'd6,  12'h03D},
    {1'b0, 4'd15, 12'h9F3},
    {1'b1, 4'd5,  12'h000},
    {1'b0, 4'd0,  12'h7FF},
    {1'b0, 4'd9,  12'h123}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ack = 1'b0;
  logic [11:0] req_data = '0;
  logic [3:0]  req_len = '0;
  logic req_ready, busy, done, ks_adv, ks_bit, mod_out;
  logic [15:0] lfsr;

  int nchk = 0, nfail = 0, cyc = 0, frames = 0;
  logic hist [0:4095];
  logic kv [0:63];
  int   kcyc [0:63];
  int   nadv = 0, acc_cyc = 0, hi_total = 0, last_done = -1, last_acc = -1;
  logic cur_ack = 1'b0;
  logic [11:0] cur_data = '0;
  logic [3:0]  cur_len = '0;
  int   idle_hi = 0, ready_busy = 0;

  always #4 clk = ~clk;

  tagtx_top #(.DIV_LOG2(DL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ack(req_ack), .req_data(req_data), .req_len(req_len), .busy(busy),
    .done(done), .ks_adv(ks_adv), .ks_bit(ks_bit), .mod_out(mod_out));

  assign ks_bit = lfsr[15];
  always @(posedge clk) begin
    if (!rst_n)      lfsr <= 16'hACE1;
    else if (ks_adv) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_frame();
    int n, w, pre, first, hi, ex, sum;
    logic e;
    n   = cur_ack ? 1 : ((cur_len > 4'd12) ? 12 : int'(cur_len));
    w   = cur_ack ? 758 : 70;
    pre = cur_ack ? 35 : 2;
    first = cyc - n * S;
    chk(first - acc_cyc >= (w - 1) * P + 2 && first - acc_cyc <= w * P + 1,
        cur_ack ? "R9 delay" : (n == 0 ? "R10 empty delay" : "R3 delay"),
        first - acc_cyc, w * P);
    chk(nadv == pre + n, "R6 strobe total", nadv, pre + n);
    if (pre + n >= 1 && nadv == pre + n && n > 0)
      chk(kcyc[pre-1] < first - 1, "R6 pre strobes early", kcyc[pre-1], first - 1);
    sum = 0;
    for (int k = 0; k < n; k++) begin
      e = cur_ack ? 1'b1 : (cur_data[k] ^ kv[pre+k]);
      chk(kcyc[pre+k] == first + k * S - 1, "R5 strobe at slot", kcyc[pre+k], first + k * S - 1);
      hi = 0;
      for (int c = 0; c < S; c++) hi += hist[(first + k * S + c) & 4095];
      ex = e ? S / 2 : 0;
      sum += ex;
      chk(hi == ex, cur_ack ? "R9 ack slot" : "R4 R7 slot level", hi, ex);
    end
    chk(hi_total == sum, "R8 quiet outside slots", hi_total, sum);
    frames++;
  endtask

  always @(negedge clk) begin
    cyc++;
    hist[cyc & 4095] = mod_out;
    if (rst_n) begin
      if (ks_adv && nadv < 64) begin kv[nadv] = ks_bit; kcyc[nadv] = cyc; nadv++; end
      if (busy) hi_total += mod_out;
      else if (mod_out) idle_hi++;
      if (busy && req_ready) ready_busy++;
      if (done) begin
        chk(!busy, "R11 busy low at done", busy, 0);
        last_done = cyc;
        check_frame();
      end
      if (req_valid && req_ready) begin
        cur_ack = req_ack; cur_data = req_data; cur_len = req_len;
        acc_cyc = cyc; last_acc = cyc; nadv = 0; hi_total = 0;
      end
    end
  end

  task automatic issue(input logic a, input logic [11:0] d, input logic [3:0] l);
    @(posedge clk); #2;
    req_valid = 1'b1; req_ack = a; req_data = d; req_len = l;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    while (frames < target) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int a_done;
    repeat (3) @(negedge clk);
    // R1 in reset
    chk(!mod_out && !busy && !done && !ks_adv && req_ready, "R1 reset",
        {mod_out, busy, done, ks_adv, req_ready}, 1);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk(!mod_out && !busy && !done && !ks_adv && req_ready, "R1 after reset",
        {mod_out, busy, done, ks_adv, req_ready}, 1);

    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][16], VEC[i][11:0], VEC[i][15:12]);
      wait_frames(i + 1);
    end

    // R2: held request taken in the done cycle of the previous frame
    issue(1'b0, 12'h5A3, 4'd10);
    issue(1'b0, 12'hC0F, 4'd12);
    a_done = last_done;
    chk(last_acc == a_done, "R2 back-to-back accept", last_acc, a_done);
    wait_frames(NVEC + 2);

    repeat (5) @(negedge clk);
    chk(idle_hi == 0, "R8 idle output", idle_hi, 0);
    chk(ready_busy == 0, "R2 ready low while busy", ready_busy, 0);
    chk(frames == NVEC + 2, "R11 done count", frames, NVEC + 2);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule